// File: doc/BRIEF.md
# Wakeup Interrupt Monitor Controller

This block stays powered while the main processor sleeps and watches a parameterised set of input pins. Each pin can be armed to catch a rising edge, a falling edge, either edge, a high level or a low level. When an armed and enabled pin sees its event, a sticky status bit is latched. The wake output is high while any enabled pin has a latched status bit.

Software reaches the block through a word-addressed register port. Pins are packed 32 to a word. Two plain timer words sit at the bottom of the map. Five banks follow them: enable, falling-edge, rising-edge, polarity and status. Each bank is `ceil(PIN_CNT/32)` words long. Before sleep, software writes zeros to the status words to clear them.

The register port carries no valid/ready handshake and has no back-pressure. Every access completes in the cycle it is presented, and read data follows one cycle later. The wake output is a plain level.

Top module: `wake_monitor`

## Requirements
- R1: After reset, every timer, enable, falling-edge, rising-edge, polarity and status word reads zero, and `wake_o` is low.
- R2: Word addresses follow the sum `bank*STRIDE + word + 2`, where STRIDE = ceil(PIN_CNT/32). The banks are numbered enable=0, falling=1, rising=2, polarity=3, status=4. The timers sit at word 0 and word 1. Pin p lives at bit p%32 of word p/32 in each bank. With the default of 40 pins, the status bank is at words 10 and 11.
- R3: The two timer words store whatever is written to them and read it back. Writing them changes no other register.
- R4: Addresses at or above `2 + 5*STRIDE` read zero, and writes to them change nothing. Bits for pins at or above PIN_CNT always read zero.
- R5: `reg_rdata` presents, one cycle after an address, that word's content from before any write made in the same cycle.
- R6: A pin whose rising bit is set flags an event on a synchronised 0-to-1 change. A pin whose falling bit is set flags an event on a 1-to-0 change. With both bits set, either change flags an event. A change on a pin's input reaches its status bit three clock edges after the change is sampled.
- R7: A pin with neither edge bit set senses a level. Its polarity bit set to 1 means active-high, and 0 means active-low. Whenever an edge bit is set, the polarity bit is not used.
- R8: An event on a pin whose enable bit is 0 leaves its status bit unchanged.
- R9: A status bit stays set until software clears it. Writing a status word clears the bits written as 0 and leaves the bits written as 1 unchanged. An event in the same cycle as a clear keeps the bit set.
- R10: `wake_o` is the OR over all pins of status AND enable. Clearing an enable bit drops the wake without clearing the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | PIN_CNT | Asynchronous wake pins |
| reg_addr | input | ADDR_W | Word address |
| reg_we | input | 1 | Write strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| wake_o | output | 1 | Wake request toward the processor |

## Verification
The hardest case to reach is an event and a software clear on the same status bit in the same cycle, because an edge lasts only one cycle at the detector. The stimulus avoids this timing problem by arming a pin for level sensing and holding it at its active level. A zero is then written to the status word, and the bit must survive. A reference model of the pipeline delay, the bank map and the status update rule runs alongside the design. It is compared against the outputs on every clock.

// File: rtl/wake_monitor_pkg.sv
package wake_monitor_pkg;
  localparam int WORD_W      = 32;
  localparam int TIMER_WORDS = 2;
  localparam int NUM_BANKS   = 5;

  typedef enum logic [2:0] {
    BK_ENABLE = 3'd0,
    BK_FALL   = 3'd1,
    BK_RISE   = 3'd2,
    BK_POL    = 3'd3,
    BK_STATUS = 3'd4
  } bank_e;

  function automatic int words_for(input int pins);
    return (pins + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/wm_sync.sv
module wm_sync #(
  parameter int N      = 40,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= pin_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= '0;
    else prev_o <= stg_q[STAGES-1];
  end

  assign cur_o = stg_q[STAGES-1];
endmodule

// File: rtl/wm_detect.sv
module wm_detect #(
  parameter int N = 40
) (
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] fall_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] evt_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic edge_mode, edge_hit, lvl_hit;
    assign edge_mode = rise_i[g] | fall_i[g];
    assign edge_hit  = (rise_i[g] & cur_i[g] & ~prev_i[g]) |
                       (fall_i[g] & ~cur_i[g] & prev_i[g]);
    assign lvl_hit   = pol_i[g] ? cur_i[g] : ~cur_i[g];
    assign evt_o[g]  = edge_mode ? edge_hit : lvl_hit;
  end
endmodule

// File: rtl/wm_regfile.sv
module wm_regfile
  import wake_monitor_pkg::*;
#(
  parameter int PIN_CNT = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [PIN_CNT-1:0] evt_i,
  output logic [PIN_CNT-1:0] enable_o,
  output logic [PIN_CNT-1:0] fall_o,
  output logic [PIN_CNT-1:0] rise_o,
  output logic [PIN_CNT-1:0] pol_o,
  output logic [PIN_CNT-1:0] status_o
);
  localparam int STRIDE = words_for(PIN_CNT);
  localparam int PADW   = STRIDE * WORD_W;
  localparam int TOTAL  = TIMER_WORDS + NUM_BANKS * STRIDE;
  localparam logic [PADW-1:0] LIVE = ~({PADW{1'b1}} << PIN_CNT);
  localparam int NCFG   = NUM_BANKS - 1;

  logic [WORD_W-1:0] timer_q [TIMER_WORDS];
  logic [PADW-1:0]   cfg_q [NCFG];
  logic [PADW-1:0]   status_q, status_n, set_vec, evt_pad;
  logic [PADW-1:0]   bank_view [NUM_BANKS];
  logic [WORD_W-1:0] rd_word;
  logic              in_bank, stat_wr;
  int                off, bsel, wsel;

  // address decode
  always_comb begin
    in_bank = (int'(bus_addr) >= TIMER_WORDS) && (int'(bus_addr) < TOTAL);
    off     = in_bank ? int'(bus_addr) - TIMER_WORDS : 0;
    bsel    = off / STRIDE;
    wsel    = off % STRIDE;
    stat_wr = bus_we && in_bank && (bsel == int'(BK_STATUS));
  end

  for (genvar t = 0; t < TIMER_WORDS; t++) begin : g_timer
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) timer_q[t] <= '0;
      else if (bus_we && int'(bus_addr) == t) timer_q[t] <= bus_wdata;
    end
  end

  for (genvar b = 0; b < NCFG; b++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[b] <= '0;
      else if (bus_we && in_bank && bsel == b)
        cfg_q[b][wsel*WORD_W +: WORD_W] <= bus_wdata & LIVE[wsel*WORD_W +: WORD_W];
    end
  end

  // sticky status: event wins over clear
  assign evt_pad = PADW'(evt_i);
  assign set_vec = evt_pad & cfg_q[int'(BK_ENABLE)];

  always_comb begin
    status_n = status_q;
    if (stat_wr)
      status_n[wsel*WORD_W +: WORD_W] = status_q[wsel*WORD_W +: WORD_W] & bus_wdata;
    status_n = status_n | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else status_q <= status_n & LIVE;
  end

  // read path
  always_comb begin
    for (int b = 0; b < NCFG; b++) bank_view[b] = cfg_q[b];
    bank_view[int'(BK_STATUS)] = status_q;
  end

  always_comb begin
    rd_word = '0;
    for (int t = 0; t < TIMER_WORDS; t++)
      if (int'(bus_addr) == t) rd_word = timer_q[t];
    if (in_bank) rd_word = bank_view[bsel][wsel*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else bus_rdata <= rd_word;
  end

  assign enable_o = cfg_q[int'(BK_ENABLE)][PIN_CNT-1:0];
  assign fall_o   = cfg_q[int'(BK_FALL)][PIN_CNT-1:0];
  assign rise_o   = cfg_q[int'(BK_RISE)][PIN_CNT-1:0];
  assign pol_o    = cfg_q[int'(BK_POL)][PIN_CNT-1:0];
  assign status_o = status_q[PIN_CNT-1:0];

  // timer word keeps its value unless addressed by a write
  assert_timer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && int'(bus_addr) == 0) |=> $stable(timer_q[0]));

  // unmapped addresses read as zero
  assert_oob_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) >= TOTAL) |=> (bus_rdata == '0));

  // read data is the pre-write content, one cycle later
  assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bus_addr) == 0) |=> (bus_rdata == $past(timer_q[0])));

  // no new status bit on a disabled pin
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(enable_o)) == '0));

  // without a status write, set bits remain set
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/wake_monitor.sv
module wake_monitor
  import wake_monitor_pkg::*;
#(
  parameter int PIN_CNT     = 40,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PIN_CNT-1:0] pins_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  output logic               wake_o
);
  logic [PIN_CNT-1:0] cur, prev, evt, enable, fall, rise, pol, status;

  wm_sync #(.N(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins_i),
    .cur_o (cur),
    .prev_o(prev)
  );

  wm_detect #(.N(PIN_CNT)) u_detect (
    .cur_i (cur),
    .prev_i(prev),
    .rise_i(rise),
    .fall_i(fall),
    .pol_i (pol),
    .evt_o (evt)
  );

  wm_regfile #(.PIN_CNT(PIN_CNT), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (reg_addr),
    .bus_we   (reg_we),
    .bus_wdata(reg_wdata),
    .bus_rdata(reg_rdata),
    .evt_i    (evt),
    .enable_o (enable),
    .fall_o   (fall),
    .rise_o   (rise),
    .pol_o    (pol),
    .status_o (status)
  );

  assign wake_o = |(status & enable);

  // an edge-armed pin only fires when its synchronised value changed
  assert_edge_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & (rise | fall) & ~(cur ^ prev)) == '0));
endmodule

// File: tb/wake_monitor_tb.sv
module wake_monitor_tb;
  localparam int PC = 40;
  localparam int ST = 2;
  localparam int NW = 2 + 5*ST;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [PC-1:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wake_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_addr(addr),
    .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .wake_o(wake)
  );

  // reference model
  bit [63:0] mb [5];
  bit [31:0] mt [2];
  bit [31:0] mr;
  bit [PC-1:0] hist [$];
  localparam bit [63:0] LIVEM = (64'h1 << PC) - 1;

  function automatic bit [31:0] model_read(input int a);
    if (a < 2) return mt[a];
    if (a < NW) return mb[(a-2)/ST][((a-2)%ST)*32 +: 32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mb[i]) mb[i] = '0;
      mt[0] = 0; mt[1] = 0; mr = 0;
      hist = '{PC'(0), PC'(0), PC'(0)};
    end else begin
      bit [63:0] setv;
      bit s, pv, rb, fb, pb, ev;
      int a;
      setv = '0;
      for (int p = 0; p < PC; p++) begin
        s = hist[1][p]; pv = hist[2][p];
        rb = mb[2][p]; fb = mb[1][p]; pb = mb[3][p];
        if (rb || fb) ev = (rb && s && !pv) || (fb && !s && pv);
        else ev = pb ? s : !s;
        setv[p] = ev && mb[0][p];
      end
      a = int'(addr);
      mr = model_read(a);
      if (we && a >= 2 + 4*ST && a < NW)
        mb[4][((a-2)%ST)*32 +: 32] = mb[4][((a-2)%ST)*32 +: 32] & wdata;
      mb[4] = (mb[4] | setv) & LIVEM;
      if (we && a < 2) mt[a] = wdata;
      else if (we && a >= 2 && a < 2 + 4*ST) begin
        mb[(a-2)/ST][((a-2)%ST)*32 +: 32] = wdata;
        mb[(a-2)/ST] &= LIVEM;
      end
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(64'(rdata), 64'(mr), "R5 model rdata");
      chk(64'(wake), 64'(|(mb[4] & mb[0])), "R10 model wake");
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 8'(a); we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = 8'(a); we = 0;
    @(negedge clk); chk(64'(rdata), 64'(e), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < NW; a++) rd(a, 32'h0, "R1 reset word");
    chk(64'(wake), 64'h0, "R1 wake low");
    // R3 timers
    wr(0, 32'hA5A5F00F);
    wr(1, 32'h00001234);
    rd(0, 32'hA5A5F00F, "R3 timer0");
    rd(1, 32'h00001234, "R3 timer1");
    rd(2, 32'h0, "R3 no side effect");
    // R4 out of range and unused pin bits
    wr(12, 32'hFFFFFFFF);
    wr(255, 32'hFFFFFFFF);
    rd(12, 32'h0, "R4 oob read");
    rd(255, 32'h0, "R4 oob read high");
    rd(10, 32'h0, "R4 status untouched");
    wr(7, 32'hFFFFFFFF);
    rd(7, 32'h000000FF, "R4 unused bits");
    wr(7, 32'h0);
    // R5 read before write in same cycle
    @(negedge clk); addr = 0; we = 1; wdata = 32'h11111111;
    @(negedge clk); we = 0;
    chk(64'(rdata), 64'hA5A5F00F, "R5 old value");
    @(negedge clk); chk(64'(rdata), 64'h11111111, "R5 new value");
    // R6 rising edge on pin 5, exact latency
    wr(6, 32'h20);
    wr(2, 32'h20);
    @(negedge clk); pins[5] = 1;
    @(negedge clk); chk(64'(wake), 64'h0, "R6 latency edge1");
    @(negedge clk); chk(64'(wake), 64'h0, "R6 latency edge2");
    @(negedge clk); chk(64'(wake), 64'h1, "R6 latency edge3");
    rd(10, 32'h20, "R2 R6 pin5 status bit");
    // R9 write semantics
    wr(10, 32'hFFFFFFFF);
    rd(10, 32'h20, "R9 ones keep");
    wr(10, 32'h0);
    rd(10, 32'h0, "R9 zero clears");
    chk(64'(wake), 64'h0, "R9 wake after clear");
    @(negedge clk); pins[5] = 0;
    idle(4);
    rd(10, 32'h0, "R6 rise ignores fall");
    // R6 falling on pin 35 (word 1 bit 3)
    wr(5, 32'h8);
    wr(3, 32'h8);
    @(negedge clk); pins[35] = 1;
    idle(4);
    rd(11, 32'h0, "R6 fall ignores rise");
    @(negedge clk); pins[35] = 0;
    idle(4);
    rd(11, 32'h8, "R2 R6 falling pin35");
    // both edges on pin 36
    wr(5, 32'h18);
    wr(7, 32'h10);
    wr(3, 32'h18);
    wr(11, 32'h0);
    @(negedge clk); pins[36] = 1;
    idle(4);
    rd(11, 32'h10, "R6 both rising");
    wr(11, 32'h0);
    @(negedge clk); pins[36] = 0;
    idle(4);
    rd(11, 32'h10, "R6 both falling");
    wr(3, 32'h0);
    wr(11, 32'h0);
    // R7 active-low level on pin 8
    wr(2, 32'h120);
    idle(2);
    rd(10, 32'h100, "R7 low level");
    wr(10, 32'h0);
    rd(10, 32'h100, "R9 event beats clear");
    @(negedge clk); pins[8] = 1;
    idle(4);
    wr(10, 32'h0);
    rd(10, 32'h0, "R7 low level released");
    // R7 active-high level on pin 7
    wr(8, 32'h80);
    wr(2, 32'h1A0);
    idle(3);
    rd(10, 32'h0, "R7 high idle");
    @(negedge clk); pins[7] = 1;
    idle(4);
    rd(10, 32'h80, "R7 high level");
    // R10 disable drops wake, keeps status
    wr(2, 32'h120);
    chk(64'(wake), 64'h0, "R10 wake off");
    rd(10, 32'h80, "R10 status kept");
    // R8 disabled pin 9 rising
    wr(6, 32'h220);
    @(negedge clk); pins[9] = 1;
    idle(4);
    rd(10, 32'h80, "R8 disabled pin");
    idle(2);
    finish_run();
  end
endmodule